// File: doc/BRIEF.md
# Replay FIFO with Half-Full Indication

This block is a single-clock first-in/first-out buffer for 9-bit words with a parameterized depth. A producer presents a word together with a one-cycle write strobe. A consumer issues one-cycle read strobes and receives each word on a registered output that carries a one-cycle valid qualifier. Three active-low flags report the fill state: empty, full, and more than half full. A write is refused while the buffer is full, and a read is refused while it is empty.

A rewind input, active low, moves the read position back to the first storage location and leaves the write position where it is. Everything written since reset can then be replayed, provided fewer than DEPTH words have been written. The flags are recomputed from the restored occupancy. Reset has priority over rewind, and a strobe that arrives during reset or rewind is dropped.

Top module: `replay_fifo`

## Requirements
- R1: While rst_n is low, both pointers return to location zero. After reset, empty_n is 0, full_n is 1, half_n is 1 and rd_valid is 0.
- R2: A write strobe while full_n is 0 is dropped. The memory and the write pointer are unchanged, and the words read out later are the ones stored before the buffer became full.
- R3: A read strobe while empty_n is 0 is dropped. rd_valid stays 0 in the following cycle and the read pointer does not move.
- R4: With no reads since reset, full_n goes to 0 in the cycle after the write that stores the DEPTH-th word, and not earlier.
- R5: empty_n goes to 0 in the cycle after the read that removes the last stored word.
- R6: half_n goes to 0 in the cycle after the write that raises occupancy above DEPTH/2. At exactly DEPTH/2 it stays 1.
- R7: half_n returns to 1 in the cycle after the read that brings occupancy back to DEPTH/2 or less.
- R8: A cycle with rtx_n low sets the read pointer to location zero and leaves the write pointer unchanged. The following reads replay the stored words from the first one, and the flags follow the restored occupancy.
- R9: Read and write strobes in a cycle with rtx_n low or rst_n low have no effect. When both rst_n and rtx_n are low, reset wins.
- R10: An accepted read sets rd_valid to 1 for exactly the next cycle, with the word on rd_data. In every other cycle rd_data is zero.
- R11: Words come out in the order they were accepted. A read and a write accepted in the same cycle leave occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_data | input | 9 | Word to store |
| rd_stb | input | 1 | One-cycle read strobe |
| rtx_n | input | 1 | Active-low rewind of the read pointer |
| rd_data | output | 9 | Registered read word, zero when not valid |
| rd_valid | output | 1 | High for the cycle after an accepted read |
| empty_n | output | 1 | Low when no words are stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
A wrong occupancy count shows up on the flags one cycle after the strobe that caused it. A full or empty flag in the wrong state then shows up as an extra or missing rd_valid pulse on the next read. A read pointer that is wrong after a rewind, or a write that slipped past a full buffer, shows up as a word mismatch on the first affected read. The scoreboard catches it there, even when the flags still look plausible.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;

  // next occupancy given the current value and the accepted strobes
  function automatic int unsigned occ_step(input int unsigned occ,
                                           input logic wr_ok,
                                           input logic rd_ok);
    int unsigned n;
    n = occ;
    if (wr_ok && !rd_ok) n = occ + 1;
    if (rd_ok && !wr_ok) n = occ - 1;
    return n;
  endfunction

  function automatic logic above_half(input int unsigned occ, input int unsigned depth);
    return occ > (depth / 2);
  endfunction

  function automatic logic at_top(input int unsigned occ, input int unsigned depth);
    return occ == depth;
  endfunction

  typedef enum logic [1:0] {
    CTL_RESET  = 2'd0,
    CTL_REWIND = 2'd1,
    CTL_RUN    = 2'd2
  } ctl_mode_e;

endpackage

// File: rtl/replay_fifo_ctrl.sv
module replay_fifo_ctrl
  import replay_fifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic          rtx_n,
  input  logic          empty_n,
  input  logic          full_n,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] occ
);

  logic [CW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  ctl_mode_e     mode;

  always_comb begin
    if (!rst_n)      mode = CTL_RESET;
    else if (!rtx_n) mode = CTL_REWIND;
    else             mode = CTL_RUN;
  end

  assign wr_acc  = (mode == CTL_RUN) && wr_stb && full_n;
  assign rd_acc  = (mode == CTL_RUN) && rd_stb && empty_n;
  assign wr_addr = wr_ptr[AW-1:0];
  assign rd_addr = rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (mode == CTL_REWIND) begin
      rd_ptr <= '0;
      occ    <= wr_ptr;
    end else begin
      if (wr_acc) wr_ptr <= wr_ptr + 1'b1;
      if (rd_acc) rd_ptr <= rd_ptr + 1'b1;
      occ <= CW'(occ_step(int'(occ), wr_acc, rd_acc));
    end
  end

  // R2: a full buffer keeps its contents when only a write is offered
  p_hold_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_stb && !rd_stb && rtx_n) |=> (occ == $past(occ) && wr_ptr == $past(wr_ptr)));

  // R3: reads on an empty buffer leave the read pointer in place
  p_hold_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rtx_n) |=> (rd_ptr == $past(rd_ptr)));

  // R9: strobes during rewind do not move the write side
  p_rewind_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rtx_n) |=> (wr_ptr == $past(wr_ptr)));

  // R11: paired read and write keep occupancy
  p_paired_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && rd_acc) |=> (occ == $past(occ)));

endmodule

// File: rtl/replay_fifo_mem.sv
module replay_fifo_mem #(
  parameter int DEPTH = 2048,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? store[rd_addr] : '0;
    end
  end

  // R10: data is zero whenever no word is presented
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid) |-> (rd_data == '0));

endmodule

// File: rtl/replay_fifo_flags.sv
module replay_fifo_flags
  import replay_fifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occ,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);

  assign empty_n = (occ != '0);
  assign full_n  = !at_top(int'(occ), DEPTH);
  assign half_n  = !above_half(int'(occ), DEPTH);

  // R1/R5: an empty buffer is neither full nor past half
  p_empty_consistent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n) |-> (full_n && half_n));

  // R6: a full buffer is past half
  p_full_past_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n) |-> (!half_n && empty_n));

endmodule

// File: rtl/replay_fifo.sv
module replay_fifo #(
  parameter int DEPTH = 2048,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_stb,
  input  logic             rtx_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);

  logic          wr_acc;
  logic          rd_acc;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] occ;

  replay_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .rtx_n(rtx_n), .empty_n(empty_n), .full_n(full_n),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .occ(occ)
  );

  replay_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_acc), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  replay_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .occ(occ),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  // R10: a valid word only follows an accepted read
  p_valid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_acc));

  // R3: an empty buffer yields no valid word next cycle
  p_no_word_when_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rtx_n) |=> !rd_valid);

endmodule

// File: tb/sim_replay_fifo.sv
`timescale 1ns/1ps
module sim_replay_fifo;
  localparam int D = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [8:0] wr_data = '0;
  logic       rd_stb = 1'b0;
  logic       rtx_n = 1'b1;
  logic [8:0] rd_data;
  logic       rd_valid, empty_n, full_n, half_n;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [8:0] mem_m [D];
  int wp_m = 0, rp_m = 0, cnt_m = 0;
  logic [8:0] exp_q [$];

  always #10 clk = ~clk;

  replay_fifo #(.DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .rtx_n(rtx_n), .rd_data(rd_data), .rd_valid(rd_valid),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_flags();
    check("R5 empty_n", empty_n, cnt_m != 0);
    check("R4 full_n", full_n, cnt_m != D);
    check("R6/R7 half_n", half_n, !(cnt_m > D/2));
  endtask

  // monitor: pops the scoreboard on every valid word (R11 order)
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected word actual=%0d expected=none", rd_data);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if (rd_data != e) begin
          fails++;
          $display("FAIL R11 order actual=%0d expected=%0d", rd_data, e);
        end
      end
    end
  end

  task automatic do_reset(input bit with_rtx);
    @(negedge clk);
    rst_n = 1'b0; wr_stb = 1'b1; rd_stb = 1'b1; rtx_n = with_rtx ? 1'b0 : 1'b1;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1; wr_stb = 1'b0; rd_stb = 1'b0; rtx_n = 1'b1;
    wp_m = 0; rp_m = 0; cnt_m = 0; exp_q.delete();
    check("R1 empty_n", empty_n, 0);
    check("R1 full_n", full_n, 1);
    check("R1 half_n", half_n, 1);
    check("R1 rd_valid", rd_valid, 0);
  endtask

  // driver: applies one cycle of strobes and updates the model
  task automatic op(input bit w, input logic [8:0] d, input bit r, input bit rt);
    bit wacc, racc;
    @(negedge clk);
    wr_stb = w; wr_data = d; rd_stb = r; rtx_n = ~rt;
    wacc = w && !rt && (cnt_m < D);
    racc = r && !rt && (cnt_m > 0);
    if (rt) begin
      rp_m = 0; cnt_m = wp_m;
    end else begin
      if (racc) begin exp_q.push_back(mem_m[rp_m]); rp_m = (rp_m + 1) % D; end
      if (wacc) begin mem_m[wp_m % D] = d; wp_m = (wp_m + 1) % (2 * D); end
      cnt_m = cnt_m + int'(wacc) - int'(racc);
    end
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0; rtx_n = 1'b1;
    check("R10 rd_valid", rd_valid, racc);
    if (!racc) check("R10 zero data", rd_data, 0);
    check_flags();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset(0);
    // R3: read on empty is dropped
    op(0, 0, 1, 0);
    // R4 R6: fill, half_n boundary at D/2 and D/2+1, full at D
    for (int i = 0; i < D; i++) op(1, 9'(i * 7 + 3), 0, 0);
    check("R4 full after DEPTH writes", full_n, 0);
    // R2: write while full is dropped
    op(1, 9'h1FF, 0, 0);
    op(1, 9'h0AA, 0, 0);
    // drain; R7 half_n clears at D/2; R5 empty at end
    for (int i = 0; i < D; i++) op(0, 0, 1, 0);
    check("R5 empty after last read", empty_n, 0);
    op(0, 0, 1, 0);
    // R11: paired read/write at occupancy 1
    op(1, 9'h011, 0, 0);
    op(1, 9'h022, 1, 0);
    check("R11 paired keeps occupancy", empty_n, 1);
    op(0, 0, 1, 0);
    check("R11 drained after pair", empty_n, 0);
    // paired when full: read accepted, write dropped (R2)
    for (int i = 0; i < D; i++) op(1, 9'(100 + i), 0, 0);
    op(1, 9'h1EE, 1, 0);
    check("R2 full pair drops write", full_n, 1);
    for (int i = 0; i < D; i++) op(0, 0, 1, 0);
    // R8/R9: rewind with strobes present
    do_reset(0);
    for (int i = 0; i < 5; i++) op(1, 9'(200 + i), 0, 0);
    for (int i = 0; i < 5; i++) op(0, 0, 1, 0);
    check("R5 empty before rewind", empty_n, 0);
    op(1, 9'h055, 1, 1);
    check("R8 rewind restores words", empty_n, 1);
    for (int i = 0; i < 5; i++) op(0, 0, 1, 0);
    check("R8 empty after replay", empty_n, 0);
    // R8 with more than half stored
    for (int i = 0; i < 6; i++) op(1, 9'(300 + i), 0, 0);
    op(0, 0, 0, 1);
    check("R8 half_n after rewind", half_n, 0);
    for (int i = 0; i < 3; i++) op(0, 0, 1, 0);
    // R9: reset wins over rewind, strobes dropped
    do_reset(1);
    op(0, 0, 1, 0);
    repeat (3) @(negedge clk);
    check("R10 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule